// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block gives a host three write-only control registers, each 14 bits wide, behind a three-wire serial link made of an enable line, a data line and a serial clock. The host pulls the enable low and clocks in a 16-bit word, most significant bit first. The upper fourteen bits carry the payload and the two bits clocked in last select the target register. When the enable goes high again, the word is committed to the selected register. The registers cannot be read back over the link.

The serial lines are asynchronous to the block's system clock. They pass through synchronisers, and edge detectors turn serial clock rises and the enable rise into single-cycle strobes. The block keeps a per-transfer bit count. A transfer that ends with fewer than sixteen clocks writes nothing and raises a one-cycle error pulse. If a transfer has more than sixteen clocks, only the last sixteen bits are used. Beside the raw registers, the block drives the decoded fields used by the rest of the chip: a 12-bit channel divide value, the reference divide ratio, and two test-routing selects with their active flags.

Top module: `tw_cfg_port`

## Requirements
- R1: While the enable is low, each rising edge of the serial clock shifts the data line into the word, most significant bit first.
- R2: While the enable is high, serial clock and data activity has no effect: it is neither shifted nor counted.
- R3: On the enable rise after a complete transfer, word bits 15..2 are copied to register bits 13..0 of the register chosen by word bits 1..0: 0 selects configuration, 1 selects channel and 2 selects test. No register changes at any other time.
- R4: When more than 16 bits are clocked in one transfer, only the last 16 bits clocked form the word.
- R5: An enable rise after fewer than 16 serial clocks, including zero, writes no register and pulses the error flag.
- R6: A complete word with address 3 is dropped: no register changes and no error is flagged.
- R7: Reset clears all three registers to zero, so the decoded channel is 0, the divide ratio is 9 and neither test route is active.
- R8: The channel number output equals channel register bits 11..0, which are word bits 13..2.
- R9: The divide-ratio select is {configuration bit 3, configuration bit 1}, which are word bits 5 and 3. The values 00, 01, 10 and 11 give ratios 9, 12, 18 and 24.
- R10: The analog test select is test register bits 2..0 (word bits 4..2) and the digital test select is bits 5..3 (word bits 7..5). Each route flag is high exactly when its select is non-zero.
- R11: The error flag is high for exactly one system clock cycle per short transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_en_i | input | 1 | Serial enable; low frames a transfer |
| ser_dat_i | input | 1 | Serial data |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| cfg_reg_o | output | 14 | Configuration register |
| chan_reg_o | output | 14 | Channel register |
| test_reg_o | output | 14 | Test register |
| chan_num_o | output | 12 | Channel divide value |
| refdiv_sel_o | output | 2 | Reference divide select |
| refdiv_ratio_o | output | 5 | Reference divide ratio (9, 12, 18 or 24) |
| atest_sel_o | output | 3 | Analog test select |
| dtest_sel_o | output | 3 | Digital test select |
| atest_on_o | output | 1 | Analog test routing active |
| dtest_on_o | output | 1 | Digital test routing active |
| short_err_o | output | 1 | One-cycle pulse on a short transfer |

## Verification
An enable rise crosses two synchroniser stages and one edge-detect stage before the strobe appears. The error pulse and the internal write strobe follow one system clock later. Register and decoded outputs settle one clock after that, about five system clocks after the enable rises. The bench therefore waits ten system clocks after each enable rise before it samples any output. It counts error pulses on falling clock edges over the whole run, so a pulse is never missed and a double pulse shows up in the count. Serial data is set up four system clocks before each serial clock rise and held four clocks after it. Data and clock cross the same number of synchroniser stages, so each bit is sampled in a known cycle.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = WORD_W - ADDR_W;
  localparam int unsigned NREG   = 3;
  localparam int unsigned CHAN_W = 12;
  localparam int unsigned TSEL_W = 3;
  localparam int unsigned RATIO_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CFG  = 2'd0,
    REG_CHAN = 2'd1,
    REG_TEST = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  function automatic logic [RATIO_W-1:0] ratio_of(input logic [1:0] sel);
    case (sel)
      2'b00:   ratio_of = RATIO_W'(9);
      2'b01:   ratio_of = RATIO_W'(12);
      2'b10:   ratio_of = RATIO_W'(18);
      default: ratio_of = RATIO_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/tw_front.sv
module tw_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_en_i,
  input  logic ser_dat_i,
  input  logic ser_clk_i,
  output logic en_s_o,
  output logic dat_s_o,
  output logic bit_stb_o,
  output logic load_stb_o
);
  // lane 0: enable (idles high), lane 1: data, lane 2: serial clock
  localparam int unsigned LANES = 3;
  localparam logic [LANES-1:0] RST_VAL = 3'b001;

  logic [STAGES-1:0][LANES-1:0] pipe_q, pipe_d;
  logic [LANES-1:0] last_q, last_d;
  logic [LANES-1:0] cur;

  assign cur = pipe_q[STAGES-1];

  always_comb begin
    pipe_d[0] = {ser_clk_i, ser_dat_i, ser_en_i};
    for (int i = 1; i < int'(STAGES); i++) pipe_d[i] = pipe_q[i-1];
    last_d = cur;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) pipe_q[i] <= RST_VAL;
      last_q <= RST_VAL;
    end else begin
      pipe_q <= pipe_d;
      last_q <= last_d;
    end
  end

  assign en_s_o     = cur[0];
  assign dat_s_o    = cur[1];
  assign bit_stb_o  = cur[2] & ~last_q[2] & ~cur[0];
  assign load_stb_o = cur[0] & ~last_q[0];
endmodule

// File: rtl/tw_shift.sv
module tw_shift
  import tw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              load_stb_i,
  input  logic              dat_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_vld_o,
  output logic              err_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d, err_q, err_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    vld_d = 1'b0;
    err_d = 1'b0;
    if (bit_stb_i) begin
      sh_d = {sh_q[WORD_W-2:0], dat_i};
      if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end
    if (load_stb_i) begin
      cnt_d = '0;
      if (cnt_q == FULL) vld_d = 1'b1;
      else               err_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign word_o   = sh_q;
  assign wr_vld_o = vld_q;
  assign err_o    = err_q;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile
  import tw_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_vld_i,
  input  logic [WORD_W-1:0]           word_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] payload;

  assign addr    = word_i[ADDR_W-1:0];
  assign payload = word_i[WORD_W-1:ADDR_W];

  for (genvar g = 0; g < int'(NREG); g++) begin : g_reg
    logic              we;
    logic [DATA_W-1:0] q, d;

    assign we = wr_vld_i && (addr == ADDR_W'(g));

    always_comb begin
      d = q;
      if (we) d = payload;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else         q <= d;
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/tw_cfg_port.sv
module tw_cfg_port
  import tw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_en_i,
  input  logic               ser_dat_i,
  input  logic               ser_clk_i,
  output logic [DATA_W-1:0]  cfg_reg_o,
  output logic [DATA_W-1:0]  chan_reg_o,
  output logic [DATA_W-1:0]  test_reg_o,
  output logic [CHAN_W-1:0]  chan_num_o,
  output logic [1:0]         refdiv_sel_o,
  output logic [RATIO_W-1:0] refdiv_ratio_o,
  output logic [TSEL_W-1:0]  atest_sel_o,
  output logic [TSEL_W-1:0]  dtest_sel_o,
  output logic               atest_on_o,
  output logic               dtest_on_o,
  output logic               short_err_o
);
  // register bit positions of the decoded fields
  localparam int unsigned RD_LO = 1;
  localparam int unsigned RD_HI = 3;
  localparam int unsigned AT_LSB = 0;
  localparam int unsigned DT_LSB = AT_LSB + TSEL_W;

  logic rst_q1, rst_n;
  logic en_s, dat_s, bit_stb, load_stb, wr_vld;
  logic [WORD_W-1:0] word;
  logic [NREG-1:0][DATA_W-1:0] regs;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q1 <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_n  <= rst_q1;
    end
  end

  tw_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .ser_en_i   (ser_en_i),
    .ser_dat_i  (ser_dat_i),
    .ser_clk_i  (ser_clk_i),
    .en_s_o     (en_s),
    .dat_s_o    (dat_s),
    .bit_stb_o  (bit_stb),
    .load_stb_o (load_stb)
  );

  tw_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .bit_stb_i  (bit_stb),
    .load_stb_i (load_stb),
    .dat_i      (dat_s),
    .word_o     (word),
    .wr_vld_o   (wr_vld),
    .err_o      (short_err_o)
  );

  tw_regfile u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_vld_i (wr_vld),
    .word_i   (word),
    .regs_o   (regs)
  );

  assign cfg_reg_o  = regs[REG_CFG];
  assign chan_reg_o = regs[REG_CHAN];
  assign test_reg_o = regs[REG_TEST];

  assign chan_num_o     = chan_reg_o[CHAN_W-1:0];
  assign refdiv_sel_o   = {cfg_reg_o[RD_HI], cfg_reg_o[RD_LO]};
  assign refdiv_ratio_o = ratio_of(refdiv_sel_o);
  assign atest_sel_o    = test_reg_o[AT_LSB +: TSEL_W];
  assign dtest_sel_o    = test_reg_o[DT_LSB +: TSEL_W];
  assign atest_on_o     = |atest_sel_o;
  assign dtest_on_o     = |dtest_sel_o;
endmodule

// File: rtl/tw_cfg_port_chk.sv
module tw_cfg_port_chk
  import tw_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_s,
  input logic               wr_vld,
  input logic [WORD_W-1:0]  word,
  input logic [DATA_W-1:0]  cfg_reg_o,
  input logic [DATA_W-1:0]  chan_reg_o,
  input logic [DATA_W-1:0]  test_reg_o,
  input logic [RATIO_W-1:0] refdiv_ratio_o,
  input logic               short_err_o
);
  // R11
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |=> !short_err_o);

  // R5
  short_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |=> ($stable(cfg_reg_o) && $stable(chan_reg_o) && $stable(test_reg_o)));

  // R6
  addr3_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_vld && word[ADDR_W-1:0] == 2'd3) |=>
      ($stable(cfg_reg_o) && $stable(chan_reg_o) && $stable(test_reg_o)));

  // R3
  write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_vld |=> ($stable(cfg_reg_o) && $stable(chan_reg_o) && $stable(test_reg_o)));

  // R2
  en_high_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s |=> $stable(word));

  // R9
  ratio_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refdiv_ratio_o == 5'd9) || (refdiv_ratio_o == 5'd12) ||
    (refdiv_ratio_o == 5'd18) || (refdiv_ratio_o == 5'd24));
endmodule

bind tw_cfg_port tw_cfg_port_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_n),
  .en_s           (en_s),
  .wr_vld         (wr_vld),
  .word           (word),
  .cfg_reg_o      (cfg_reg_o),
  .chan_reg_o     (chan_reg_o),
  .test_reg_o     (test_reg_o),
  .refdiv_ratio_o (refdiv_ratio_o),
  .short_err_o    (short_err_o)
);

// File: tb/tw_cfg_port_tb.sv
module tw_cfg_port_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_en = 1'b1, ser_dat = 1'b0, ser_clk = 1'b0;
  logic [13:0] cfg_reg, chan_reg, test_reg;
  logic [11:0] chan_num;
  logic [1:0]  refdiv_sel;
  logic [4:0]  refdiv_ratio;
  logic [2:0]  atest_sel, dtest_sel;
  logic        atest_on, dtest_on, short_err;

  int n_chk = 0, n_bad = 0, n_err = 0;
  bit done = 1'b0;
  logic [13:0] m_cfg = '0, m_chan = '0, m_test = '0;

  always #2 clk = ~clk;

  tw_cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_en_i(ser_en), .ser_dat_i(ser_dat),
    .ser_clk_i(ser_clk), .cfg_reg_o(cfg_reg), .chan_reg_o(chan_reg),
    .test_reg_o(test_reg), .chan_num_o(chan_num), .refdiv_sel_o(refdiv_sel),
    .refdiv_ratio_o(refdiv_ratio), .atest_sel_o(atest_sel), .dtest_sel_o(dtest_sel),
    .atest_on_o(atest_on), .dtest_on_o(dtest_on), .short_err_o(short_err)
  );

  always @(negedge clk) if (short_err) n_err++;

  typedef struct packed {
    logic [15:0] w;
    logic [11:0] ch;
    logic [4:0]  rt;
    logic [2:0]  at;
    logic [2:0]  dt;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{16'h0028, 12'd0,    5'd24, 3'd0, 3'd0},
    '{16'h0008, 12'd0,    5'd12, 3'd0, 3'd0},
    '{16'h0020, 12'd0,    5'd18, 3'd0, 3'd0},
    '{16'h0641, 12'd400,  5'd18, 3'd0, 3'd0},
    '{16'hFFFD, 12'd4095, 5'd18, 3'd0, 3'd0},
    '{16'h0096, 12'd4095, 5'd18, 3'd5, 3'd4},
    '{16'h001E, 12'd4095, 5'd18, 3'd7, 3'd0},
    '{16'hFFFC, 12'd4095, 5'd24, 3'd7, 3'd0},
    '{16'h0005, 12'd1,    5'd24, 3'd7, 3'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sclk_pulse(input logic d);
    ser_dat = d;
    cyc(4);
    ser_clk = 1'b1;
    cyc(4);
    ser_clk = 1'b0;
  endtask

  // n bits of b, most significant first, framed by the enable
  task automatic xfer(input logic [31:0] b, input int n);
    cyc(2);
    ser_en = 1'b0;
    cyc(4);
    for (int i = n - 1; i >= 0; i--) sclk_pulse(b[i]);
    cyc(2);
    ser_en = 1'b1;
    cyc(10);
  endtask

  task automatic model_write(input logic [15:0] w);
    case (w[1:0])
      2'd0: m_cfg  = w[15:2];
      2'd1: m_chan = w[15:2];
      2'd2: m_test = w[15:2];
      default: ;
    endcase
  endtask

  task automatic check_regs(input string req);
    check(req, int'(cfg_reg), int'(m_cfg));
    check(req, int'(chan_reg), int'(m_chan));
    check(req, int'(test_reg), int'(m_test));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int e0;
    cyc(5);
    rst_ni = 1'b1;
    cyc(5);
    // R7 reset state
    check_regs("R7");
    check("R7", int'(refdiv_ratio), 9);
    check("R7", int'({atest_on, dtest_on}), 0);
    check("R11", n_err, 0);

    // table: R1 R3 R8 R9 R10
    foreach (TBL[i]) begin
      e0 = n_err;
      xfer({16'h0, TBL[i].w}, 16);
      model_write(TBL[i].w);
      check_regs("R3");
      check("R8", int'(chan_num), int'(TBL[i].ch));
      check("R9", int'(refdiv_ratio), int'(TBL[i].rt));
      check("R9", int'(refdiv_sel), int'({m_cfg[3], m_cfg[1]}));
      check("R10", int'(atest_sel), int'(TBL[i].at));
      check("R10", int'(dtest_sel), int'(TBL[i].dt));
      check("R10", int'(atest_on), int'(TBL[i].at != 0));
      check("R10", int'(dtest_on), int'(TBL[i].dt != 0));
      check("R1", n_err - e0, 0);
    end

    // R4: 20 bits, last 16 form the word (channel 641)
    e0 = n_err;
    xfer({12'h0, 4'b1010, 16'h0A05}, 20);
    model_write(16'h0A05);
    check("R4", int'(chan_num), 641);
    check_regs("R4");
    check("R4", n_err - e0, 0);

    // R5 R11: 10-bit short transfer
    e0 = n_err;
    xfer(32'h3FD, 10);
    check_regs("R5");
    check("R11", n_err - e0, 1);

    // R5: enable pulse with no clocks
    e0 = n_err;
    xfer(32'h0, 0);
    check_regs("R5");
    check("R5", n_err - e0, 1);

    // R6: address 3 dropped
    e0 = n_err;
    xfer(32'h1237, 16);
    check_regs("R6");
    check("R6", n_err - e0, 0);

    // R2: clocks with enable high must not count toward the next transfer
    e0 = n_err;
    for (int k = 0; k < 12; k++) sclk_pulse(1'b1);
    xfer(32'h3D, 6);
    check_regs("R2");
    check("R2", n_err - e0, 1);

    // R7: reset mid-run
    rst_ni = 1'b0;
    cyc(3);
    m_cfg = '0; m_chan = '0; m_test = '0;
    check_regs("R7");
    check("R7", int'(refdiv_ratio), 9);
    rst_ni = 1'b1;
    cyc(5);
    xfer(32'h0641, 16);
    check("R7", int'(chan_num), 400);

    finish_run();
  end
endmodule